// File: doc/BRIEF.md
# FP8 Widening Scaled Multiply-Accumulate Lane

This lane takes two 8-bit floating-point operands and a half-precision accumulator value and returns one updated half-precision value. Each narrow operand has its own format select, so the two operands may use different 8-bit encodings. The lane forms the exact product of the two operands and scales it down by a power of two from 0 to 15. It adds the scaled product to the accumulator exactly and rounds once to half precision. The result replaces the accumulator value, so the caller feeds it back as the next accumulator operand.

Operands enter through a valid/ready handshake. The whole datapath is combinational and is captured in one output register, which holds its value until the consumer accepts it. Two sticky flags record invalid operations and overflows since the last reset.

Top module: `f8w_mac_lane`

## Requirements
- R1: With `rmode` 0, `result` equals `acc + op_a*op_b*2^-scale`, rounded once to half precision with round-to-nearest-even. The sum is held exactly before that rounding.
- R2: Select bit 0 decodes an operand as E5M2 (sign, 5 exponent bits with bias 15, 2 mantissa bits; exponent 31 gives infinity for mantissa 0 and NaN otherwise). Select bit 1 decodes it as E4M3 (sign, 4 exponent bits with bias 7, 3 mantissa bits; no infinity; NaN only when the low 7 bits are all ones). `fmt_a` and `fmt_b` act independently of each other.
- R3: The product, and only the product, is multiplied by 2^-scale, where `scale` is an unsigned value from 0 to 15.
- R4: `rmode` selects the rounding: 0 nearest-even, 1 toward +infinity, 2 toward -infinity, 3 toward zero.
- R5: A NaN in `op_a`, `op_b` or `acc` gives the quiet NaN 0x7E00.
- R6: Infinity times zero gives 0x7E00, and so does an infinite product added to an accumulator infinity of the opposite sign. Both set `flag_invalid`. An infinite product with no such conflict gives an infinity of the product's sign. An infinite accumulator with a finite product passes through unchanged.
- R7: A finite result whose rounded magnitude exceeds 65504 sets `flag_overflow`. It gives an infinity of the result's sign when the rounding heads away from zero: mode 0 for either sign, mode 1 for a positive result, mode 2 for a negative result. In every other case it gives the signed maximum finite value 0x7BFF or 0xFBFF.
- R8: An exact zero sum is +0, with two exceptions. When both addends are -0 the result is -0. In mode 2 an exact zero from addends of opposite sign is -0.
- R9: Subnormal 8-bit inputs are converted exactly. Results below the half-precision normal range become correctly rounded half-precision subnormals.
- R10: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A held result stays stable until it is accepted. Results appear one cycle after acceptance, in order.
- R11: After a reset cycle, `out_valid`, `flag_invalid` and `flag_overflow` are low.
- R12: Once set, `flag_invalid` and `flag_overflow` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Lane can accept an operand set |
| op_a | input | 8 | First 8-bit floating-point operand |
| op_b | input | 8 | Second 8-bit floating-point operand |
| fmt_a | input | 1 | Encoding select for op_a (0 E5M2, 1 E4M3) |
| fmt_b | input | 1 | Encoding select for op_b (0 E5M2, 1 E4M3) |
| scale | input | 4 | Product is scaled by 2^-scale |
| rmode | input | 2 | Rounding mode |
| acc | input | 16 | Half-precision accumulator operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 16 | Updated half-precision accumulator value |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_overflow | output | 1 | Sticky overflow flag |

## Verification
Two things can happen at the same clock edge: the consumer drains the held result, and a new operand set is accepted into the same register. The bench provokes this in two ways. It streams three operand sets on consecutive cycles with `out_ready` high. It also releases a stalled output while the next operand is already waiting. In both cases every result must appear exactly one cycle after its own acceptance, with no result lost or repeated. A sticky flag update can land on that same edge, and the bench checks that the flag does not fall when a clean result follows an invalid one.

// File: rtl/f8w_pkg.sv
// Shared constants and types for the FP8 widening multiply-accumulate lane.
// Assumes: all arithmetic is done on an exact fixed-point grid whose LSB is
// the smallest possible scaled-product quantum (2^-GRID_BIAS).
package f8w_pkg;
    localparam int F8_W      = 8;
    localparam int H_W       = 16;
    localparam int H_MAN_W   = 10;
    localparam int H_PREC    = H_MAN_W + 1;
    localparam int SCALE_W   = 4;
    localparam int RM_W      = 2;
    localparam int SIG8_W    = 4;
    localparam int PROD_W    = 2 * SIG8_W;
    // Smallest LSB exponent of a decoded 8-bit significand is -F8_EMIN.
    localparam int F8_EMIN   = 17;
    // Largest LSB exponent of a decoded 8-bit significand.
    localparam int F8_EMAX   = 12;
    localparam int GRID_BIAS = 2 * F8_EMIN + (2 ** SCALE_W - 1);
    // Half-precision smallest quantum is 2^-H_LSB_EXP.
    localparam int H_LSB_EXP = 24;
    localparam int GRID_SUB  = GRID_BIAS - H_LSB_EXP;
    localparam int SUM_W     = GRID_BIAS + 2 * F8_EMAX + PROD_W + 3;
    localparam int SH_W      = $clog2(SUM_W);

    localparam logic [H_W-1:0] H_QNAN = 16'h7E00;

    typedef enum logic [RM_W-1:0] {
        RND_NEAR = 2'd0,
        RND_UP   = 2'd1,
        RND_DOWN = 2'd2,
        RND_ZERO = 2'd3
    } rnd_e;

    typedef struct packed {
        logic                     sign;
        logic [SIG8_W-1:0]        sig;
        logic signed [5:0]        exp;   // exponent of the significand LSB
        logic                     zero;
        logic                     inf;
        logic                     nan;
    } f8_val_t;
endpackage

// File: rtl/f8w_decode.sv
// Unpacks one 8-bit floating-point code into sign, integer significand and
// LSB exponent. fmt=0 selects E5M2 (bias 15, IEEE specials), fmt=1 selects
// E4M3 (bias 7, no infinity, NaN only for all-ones magnitude).
// Assumes: pure combinational, subnormals are returned exactly.
module f8w_decode
    import f8w_pkg::*;
(
    input  logic [F8_W-1:0] code,
    input  logic            fmt,
    output f8_val_t         val
);
    logic [4:0] e5;
    logic [1:0] m2;
    logic [3:0] e4;
    logic [2:0] m3;

    assign e5 = code[6:2];
    assign m2 = code[1:0];
    assign e4 = code[6:3];
    assign m3 = code[2:0];

    // Decode the selected format into the shared unpacked form.
    always_comb begin
        val      = '0;
        val.sign = code[7];
        if (!fmt) begin
            if (e5 == 5'h1F) begin
                val.inf = (m2 == 2'b00);
                val.nan = (m2 != 2'b00);
            end else if (e5 == 5'h00) begin
                val.sig  = {1'b0, m2, 1'b0};
                val.exp  = -6'sd17;
                val.zero = (m2 == 2'b00);
            end else begin
                val.sig = {1'b1, m2, 1'b0};
                val.exp = $signed({1'b0, e5}) - 6'sd18;
            end
        end else begin
            if (e4 == 4'hF && m3 == 3'h7) begin
                val.nan = 1'b1;
            end else if (e4 == 4'h0) begin
                val.sig  = {1'b0, m3};
                val.exp  = -6'sd9;
                val.zero = (m3 == 3'h0);
            end else begin
                val.sig = {1'b1, m3};
                val.exp = $signed({2'b00, e4}) - 6'sd10;
            end
        end
    end
endmodule

// File: rtl/f8w_round.sv
// Rounds an exact sign-magnitude value on the fixed-point grid (LSB weight
// 2^-GRID_BIAS) to half precision under one of four rounding modes.
// Assumes: a zero magnitude returns a zero with the supplied sign.
module f8w_round
    import f8w_pkg::*;
(
    input  logic [SUM_W-1:0] mag,
    input  logic             sign,
    input  logic [RM_W-1:0]  rmode,
    output logic [H_W-1:0]   bits,
    output logic             overflow
);
    logic [SH_W-1:0]    lead;
    logic [SH_W-1:0]    sh;
    logic [H_PREC-1:0]  q0;
    logic               guard;
    logic               sticky;
    logic               inc;
    logic [H_PREC:0]    q;
    logic [7:0]         bexp;
    logic [H_MAN_W-1:0] man;
    logic [SUM_W-1:0]   below;
    logic               to_inf;

    // Locate the most significant set bit of the magnitude.
    always_comb begin
        lead = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (mag[i]) lead = SH_W'(i);
        end
    end

    // Choose the rounding position: 11 significant bits, floored at the subnormal quantum.
    assign sh     = (lead > SH_W'(GRID_SUB + H_MAN_W)) ? lead - SH_W'(H_MAN_W) : SH_W'(GRID_SUB);
    assign q0     = H_PREC'(mag >> sh);
    assign guard  = mag[sh - SH_W'(1)];
    assign below  = ~({SUM_W{1'b1}} << (sh - SH_W'(1)));
    assign sticky = |(mag & below);

    // Decide the increment from the rounding mode, guard and sticky bits.
    always_comb begin
        case (rnd_e'(rmode))
            RND_NEAR: inc = guard & (sticky | q0[0]);
            RND_UP:   inc = (guard | sticky) & ~sign;
            RND_DOWN: inc = (guard | sticky) & sign;
            default:  inc = 1'b0;
        endcase
    end

    assign q = {1'b0, q0} + {{H_PREC{1'b0}}, inc};

    // Form the biased exponent and mantissa, absorbing a rounding carry.
    always_comb begin
        if (q[H_PREC]) begin
            bexp = 8'(sh) - 8'(H_LSB_EXP - 1);
            man  = '0;
        end else if (q[H_PREC-1]) begin
            bexp = 8'(sh) - 8'(H_LSB_EXP);
            man  = q[H_MAN_W-1:0];
        end else begin
            bexp = 8'd0;
            man  = q[H_MAN_W-1:0];
        end
    end

    assign overflow = (bexp >= 8'd31);
    assign to_inf   = (rnd_e'(rmode) == RND_NEAR) |
                      ((rnd_e'(rmode) == RND_UP) & ~sign) |
                      ((rnd_e'(rmode) == RND_DOWN) & sign);

    // Pack the final half-precision code, saturating on overflow.
    always_comb begin
        if (overflow) bits = to_inf ? {sign, 5'h1F, 10'h000} : {sign, 5'h1E, 10'h3FF};
        else          bits = {sign, bexp[4:0], man};
    end
endmodule

// File: rtl/f8w_mac_lane.sv
// FP8 widening scaled multiply-accumulate lane. Decodes two 8-bit operands,
// forms their exact product scaled by 2^-scale, adds it exactly to a
// half-precision accumulator and rounds once. One output register with a
// valid/ready handshake; sticky invalid and overflow flags.
// Assumes: synchronous active-low reset; in_ready is combinational.
module f8w_mac_lane
    import f8w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [F8_W-1:0]    op_a,
    input  logic [F8_W-1:0]    op_b,
    input  logic               fmt_a,
    input  logic               fmt_b,
    input  logic [SCALE_W-1:0] scale,
    input  logic [RM_W-1:0]    rmode,
    input  logic [H_W-1:0]     acc,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [H_W-1:0]     result,
    output logic               flag_invalid,
    output logic               flag_overflow
);
    logic [F8_W-1:0] opnd    [2];
    logic            fmt_sel [2];
    f8_val_t         op_dec  [2];

    assign opnd[0]    = op_a;
    assign opnd[1]    = op_b;
    assign fmt_sel[0] = fmt_a;
    assign fmt_sel[1] = fmt_b;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        f8w_decode u_dec (
            .code (opnd[g]),
            .fmt  (fmt_sel[g]),
            .val  (op_dec[g])
        );
    end

    // Product path.
    logic              p_sign, p_inf, p_zero, p_nan;
    logic [PROD_W-1:0] p_sig;
    logic signed [7:0] p_exp;
    logic [SH_W-1:0]   p_sh;
    logic [SUM_W-1:0]  p_mag;

    assign p_sign = op_dec[0].sign ^ op_dec[1].sign;
    assign p_inf  = op_dec[0].inf | op_dec[1].inf;
    assign p_zero = op_dec[0].zero | op_dec[1].zero;
    assign p_nan  = op_dec[0].nan | op_dec[1].nan;
    assign p_sig  = PROD_W'(op_dec[0].sig) * PROD_W'(op_dec[1].sig);
    assign p_exp  = 8'($signed(op_dec[0].exp)) + 8'($signed(op_dec[1].exp))
                  - $signed({4'b0000, scale});
    assign p_sh   = SH_W'(p_exp + 8'(GRID_BIAS));
    assign p_mag  = SUM_W'(p_sig) << p_sh;

    // Accumulator path.
    logic             a_sign, a_inf, a_nan;
    logic [4:0]       a_e, a_e_eff;
    logic [H_MAN_W-1:0] a_m;
    logic [H_PREC-1:0]  a_sig;
    logic [SH_W-1:0]  a_sh;
    logic [SUM_W-1:0] a_mag;

    assign a_sign  = acc[15];
    assign a_e     = acc[14:10];
    assign a_m     = acc[9:0];
    assign a_inf   = (a_e == 5'h1F) && (a_m == '0);
    assign a_nan   = (a_e == 5'h1F) && (a_m != '0);
    assign a_sig   = {(a_e != 5'h00), a_m};
    assign a_e_eff = (a_e == 5'h00) ? 5'd1 : a_e;
    assign a_sh    = SH_W'(a_e_eff) + SH_W'(GRID_SUB - 1);
    assign a_mag   = SUM_W'(a_sig) << a_sh;

    // Exact signed addition on the grid, with the zero-sign rule.
    logic [SUM_W-1:0] s_mag;
    logic             s_sign;
    always_comb begin
        if (p_sign == a_sign) begin
            s_mag  = p_mag + a_mag;
            s_sign = p_sign;
        end else if (p_mag >= a_mag) begin
            s_mag  = p_mag - a_mag;
            s_sign = p_sign;
        end else begin
            s_mag  = a_mag - p_mag;
            s_sign = a_sign;
        end
        if (s_mag == '0 && p_sign != a_sign) s_sign = (rnd_e'(rmode) == RND_DOWN);
    end

    logic [H_W-1:0] rnd_bits;
    logic           rnd_ovf;

    f8w_round u_round (
        .mag      (s_mag),
        .sign     (s_sign),
        .rmode    (rmode),
        .bits     (rnd_bits),
        .overflow (rnd_ovf)
    );

    // Special-value resolution ahead of the result register.
    logic           nan_in, inv_w, nan_w, ovf_w;
    logic [H_W-1:0] res_d;
    assign nan_in = p_nan | a_nan;
    assign inv_w  = ~nan_in & p_inf & (p_zero | (a_inf & (p_sign != a_sign)));
    assign nan_w  = nan_in | inv_w;
    assign ovf_w  = ~nan_w & ~p_inf & ~a_inf & rnd_ovf;

    // Select NaN, infinity, accumulator passthrough or the rounded sum.
    always_comb begin
        if (nan_w)      res_d = H_QNAN;
        else if (p_inf) res_d = {p_sign, 15'h7C00};
        else if (a_inf) res_d = acc;
        else            res_d = rnd_bits;
    end

    logic in_fire;
    assign in_ready = !out_valid || out_ready;
    assign in_fire  = in_valid && in_ready;

    // Output register and handshake state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            result    <= res_d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Sticky exception flags, set on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_invalid  <= 1'b0;
            flag_overflow <= 1'b0;
        end else if (in_fire) begin
            flag_invalid  <= flag_invalid | inv_w;
            flag_overflow <= flag_overflow | ovf_w;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result));

    p_nan_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && nan_in |=> result == H_QNAN);

    p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && inv_w |=> flag_invalid && result == H_QNAN);

    p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && ovf_w && rmode == 2'd0 |=> flag_overflow && result[14:0] == 15'h7C00);

    p_inv_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |=> flag_invalid);

    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |=> flag_overflow);

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !flag_invalid && !flag_overflow);
endmodule

// File: tb/f8w_mac_lane_bench.sv
module f8w_mac_lane_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [7:0]  op_a, op_b;
    logic        fmt_a, fmt_b;
    logic [3:0]  scale;
    logic [1:0]  rmode;
    logic [15:0] acc;
    logic        out_valid, out_ready;
    logic [15:0] result;
    logic        flag_invalid, flag_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    f8w_mac_lane u_f8w_mac_lane (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_a(op_a), .op_b(op_b), .fmt_a(fmt_a), .fmt_b(fmt_b),
        .scale(scale), .rmode(rmode), .acc(acc),
        .out_valid(out_valid), .out_ready(out_ready), .result(result),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic [7:0]  a;
        logic [7:0]  b;
        logic        fa;
        logic        fb;
        logic [3:0]  sc;
        logic [1:0]  rm;
        logic [15:0] acc;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{8'd1, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h3C00, 16'h4000}, // R1 1*1+1
        '{8'd2, 8'h3C, 8'h40, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h4200}, // R2 E4M3 1.5*2
        '{8'd2, 8'h3E, 8'h3C, 1'b0, 1'b1, 4'd0,  2'd0, 16'h3400, 16'h4100}, // R2 mixed 1.5*1.5+0.25
        '{8'd2, 8'h40, 8'h40, 1'b1, 1'b0, 4'd0,  2'd0, 16'h0000, 16'h4400}, // R2 E4M3 2 * E5M2 2
        '{8'd2, 8'h38, 8'h38, 1'b0, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h3800}, // R2 E5M2 0.5 * E4M3 1
        '{8'd2, 8'h7E, 8'h38, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h5F00}, // R2 E4M3 448 finite
        '{8'd2, 8'h7C, 8'h38, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h5E00}, // R2 E4M3 384
        '{8'd2, 8'h7C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0000, 16'h7C00}, // R2 E5M2 inf
        '{8'd3, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd3,  2'd0, 16'h3C00, 16'h3C80}, // R3 scale 3
        '{8'd3, 8'h40, 8'h40, 1'b0, 1'b0, 4'd15, 2'd0, 16'h0000, 16'h0800}, // R3 scale 15
        '{8'd3, 8'h7E, 8'h7E, 1'b1, 1'b1, 4'd2,  2'd0, 16'h0000, 16'h7A20}, // R3 scale 2
        '{8'd3, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd15, 2'd0, 16'h4000, 16'h4000}, // R3 acc unscaled
        '{8'd1, 8'h3E, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd0, 16'h3C00, 16'h3C01}, // R1 0.75 ulp up
        '{8'd4, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd0, 16'h3C00, 16'h3C00}, // R4 tie to even
        '{8'd4, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd1, 16'h3C00, 16'h3C01}, // R4 up
        '{8'd4, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd3, 16'h3C00, 16'h3C00}, // R4 zero
        '{8'd4, 8'hBC, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd2, 16'hBC00, 16'hBC01}, // R4 down negative
        '{8'd4, 8'hBC, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd1, 16'hBC00, 16'hBC00}, // R4 up negative
        '{8'd4, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd11, 2'd0, 16'h3C01, 16'h3C02}, // R4 tie to even up
        '{8'd5, 8'h7F, 8'h38, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h7E00}, // R5 E4M3 NaN
        '{8'd5, 8'h7D, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0000, 16'h7E00}, // R5 E5M2 NaN
        '{8'd5, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h7E01, 16'h7E00}, // R5 acc NaN
        '{8'd6, 8'h7C, 8'h00, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0000, 16'h7E00}, // R6 inf*0
        '{8'd6, 8'h7C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'hFC00, 16'h7E00}, // R6 inf-inf
        '{8'd6, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'hFC00, 16'hFC00}, // R6 acc inf passes
        '{8'd7, 8'h7E, 8'h7E, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h7C00}, // R7 nearest to inf
        '{8'd7, 8'h7E, 8'h7E, 1'b1, 1'b1, 4'd0,  2'd3, 16'h0000, 16'h7BFF}, // R7 zero to max
        '{8'd7, 8'hFE, 8'h7E, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'hFC00}, // R7 negative inf
        '{8'd7, 8'hFE, 8'h7E, 1'b1, 1'b1, 4'd0,  2'd1, 16'h0000, 16'hFBFF}, // R7 up negative max
        '{8'd7, 8'hFE, 8'h7E, 1'b1, 1'b1, 4'd0,  2'd2, 16'h0000, 16'hFC00}, // R7 down negative inf
        '{8'd8, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'hBC00, 16'h0000}, // R8 cancel nearest
        '{8'd8, 8'h3C, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd2, 16'hBC00, 16'h8000}, // R8 cancel down
        '{8'd8, 8'h80, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h8000, 16'h8000}, // R8 -0 + -0
        '{8'd8, 8'h80, 8'h3C, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0000, 16'h0000}, // R8 -0 + +0
        '{8'd9, 8'h01, 8'h01, 1'b1, 1'b1, 4'd0,  2'd0, 16'h0000, 16'h0040}, // R9 sub*sub
        '{8'd9, 8'h01, 8'h01, 1'b1, 1'b1, 4'd7,  2'd0, 16'h0000, 16'h0000}, // R9 half quantum tie
        '{8'd9, 8'h01, 8'h01, 1'b1, 1'b1, 4'd6,  2'd0, 16'h0000, 16'h0001}, // R9 one quantum
        '{8'd9, 8'h01, 8'h0C, 1'b1, 1'b1, 4'd10, 2'd0, 16'h0000, 16'h0001}  // R9 0.75 quantum
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_op(input vec_t v);
        op_a = v.a; op_b = v.b; fmt_a = v.fa; fmt_b = v.fb;
        scale = v.sc; rmode = v.rm; acc = v.acc;
    endtask

    // Issue one operation at a falling edge, return at the falling edge after acceptance.
    task automatic issue(input vec_t v);
        set_op(v);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        set_op(VEC[0]);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 out_valid", {15'd0, out_valid}, 16'd0);
        chk("R11 flags", {14'd0, flag_invalid, flag_overflow}, 16'd0);
        chk("R10 ready idle", {15'd0, in_ready}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string msg;
            issue(VEC[i]);
            msg = $sformatf("R%0d vector %0d", VEC[i].tag, i);
            chk(msg, result, VEC[i].exp);
        end

        // R11: reset clears flags that the table set
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 flags after reset", {14'd0, flag_invalid, flag_overflow}, 16'd0);
        chk("R11 out_valid after reset", {15'd0, out_valid}, 16'd0);
        issue(VEC[0]);
        chk("R12 clean op no flags", {14'd0, flag_invalid, flag_overflow}, 16'd0);
        issue(VEC[22]);   // inf*0
        chk("R6 invalid flag set", {14'd0, flag_invalid, flag_overflow}, 16'b10);
        issue(VEC[0]);
        chk("R12 invalid stays", {14'd0, flag_invalid, flag_overflow}, 16'b10);
        issue(VEC[25]);   // overflow
        chk("R7 overflow flag set", {14'd0, flag_invalid, flag_overflow}, 16'b11);
        issue(VEC[1]);
        chk("R12 both stay", {14'd0, flag_invalid, flag_overflow}, 16'b11);

        // R10 streaming: accept and drain on the same edge
        set_op(VEC[0]); in_valid = 1'b1;
        @(negedge clk);
        chk("R10 stream first", result, VEC[0].exp);
        set_op(VEC[1]);
        @(negedge clk);
        chk("R10 stream second", result, VEC[1].exp);
        set_op(VEC[2]);
        @(negedge clk);
        chk("R10 stream third", result, VEC[2].exp);
        chk("R10 stream valid", {15'd0, out_valid}, 16'd1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10 drained", {15'd0, out_valid}, 16'd0);

        // R10 stall: held result stays while next op waits
        out_ready = 1'b0;
        set_op(VEC[3]); in_valid = 1'b1;
        @(negedge clk);
        chk("R10 stall result", result, VEC[3].exp);
        set_op(VEC[8]);
        chk("R10 stall not ready", {15'd0, in_ready}, 16'd0);
        @(negedge clk);
        chk("R10 held stable", result, VEC[3].exp);
        chk("R10 held valid", {15'd0, out_valid}, 16'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 release next", result, VEC[8].exp);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule